// File: doc/BRIEF.md
# 24-bit Effective Address Generator

This block turns an addressing-mode code, the operand bytes of an instruction and a snapshot of the processor's bank, direct-page, index and stack registers into a 24-bit effective address. Direct modes produce the address one cycle after the request. Indirect modes first read a 16-bit or 24-bit pointer one byte per cycle through a simple memory port. The pointer is then combined with the data bank, the program bank or the Y index to form the final address.

A request is a one-cycle `start_i` pulse while the block is idle. Every register input is captured on that edge, so the caller may change them during a pointer fetch. The result appears on `ea_o` with a one-cycle `ea_valid_o` strobe. An unused mode code gives a one-cycle `ea_err_o` strobe instead. Instruction decode and the final data access belong to the surrounding pipeline.

Top module: `ea_gen`

## Requirements
- R1: After reset, `ea_valid_o`, `ea_err_o`, `busy_o` and `mem_rd_o` are all low.
- R2: Mode 0 yields {data bank, operand bytes 1:0} and mode 1 yields {program bank, operand bytes 1:0}. Operand byte 0 is the least significant.
- R3: Modes 2 (X) and 3 (Y) form {data bank, operand bytes 1:0} and add the index as a full 24-bit sum, so a carry moves into the bank byte. The sum wraps modulo 2^24.
- R4: When `idx8_i` is 1, every use of X or Y takes only the low 8 bits of the register, with the upper byte treated as zero.
- R5: Modes 4, 5 (X) and 6 (Y) give bank 0 with offset (direct page + operand byte 0 [+ index]) mod 2^16.
- R6: Mode 7 reads a 2-byte pointer at bank 0, offset direct page + operand byte 0, and gives {data bank, pointer} + Y (24-bit). Mode 8 reads a 3-byte pointer at the same place and gives pointer + Y (24-bit).
- R7: Mode 9 reads a 2-byte pointer at bank 0, offset (stack pointer + operand byte 0) mod 2^16, and gives {data bank, pointer} + Y (24-bit).
- R8: Mode 10 reads a 2-byte pointer at bank 0, offset operand bytes 1:0. Mode 11 reads it at {program bank, (operand bytes 1:0 + X) mod 2^16}. Both give {program bank, pointer}.
- R9: Mode 12 gives operand bytes 2:0 as bank:high:low. Mode 13 gives that value + X (24-bit).
- R10: Pointer bytes are read at the base offset, then base+1, then base+2. The 16-bit offset wraps and the bank byte stays the same. The first byte read is the least significant byte of the pointer.
- R11: Direct modes raise `ea_valid_o` in the cycle after `start_i`. Indirect modes assert `mem_rd_o` for one byte per cycle from the cycle after `start_i`, sampling `mem_rdata_i` in the same cycle. `ea_valid_o` rises in the cycle after the last read, so 2-byte modes take 3 cycles and 3-byte modes take 4.
- R12: Mode codes 14 and 15 raise `ea_err_o` for one cycle in the cycle after `start_i`. They issue no memory read and no `ea_valid_o`.
- R13: `start_i` is ignored while `busy_o` is high. The ongoing request finishes with the inputs captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| mode_i | input | 4 | Addressing-mode code |
| opnd_i | input | 24 | Operand bytes, byte 0 in bits 7:0 |
| dbank_i | input | 8 | Data bank register |
| pbank_i | input | 8 | Program bank register |
| dpage_i | input | 16 | Direct-page register |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| sp_i | input | 16 | Stack pointer |
| idx8_i | input | 1 | Index registers are 8 bits wide |
| mem_rd_o | output | 1 | Pointer byte read strobe |
| mem_addr_o | output | 24 | Pointer byte address |
| mem_rdata_i | input | 8 | Read data, valid in the strobe cycle |
| busy_o | output | 1 | Pointer fetch in progress |
| ea_o | output | 24 | Effective address |
| ea_valid_o | output | 1 | One-cycle result strobe |
| ea_err_o | output | 1 | One-cycle unused-mode strobe |

## Verification
All sixteen mode codes are swept with both index widths. Each combination is tried against two hand-built corner patterns and several pseudo-random register sets, and the expected address is computed arithmetically.

One corner pattern places the data bank at FF and the direct page and stack pointer near FFFF. This separates a true 24-bit index carry from a 16-bit wrap, and shows that direct-page, stack-relative and pointer-byte offsets wrap without touching the bank. An index with a nonzero upper byte shows whether the 8-bit width setting masks it.

The memory model returns an address-dependent byte, so swapped pointer bytes, a wrong pointer bank and a misplaced base all change the result. Each run also checks the cycle of the strobe and the exact read address sequence. A request issued in the middle of a fetch checks that it is ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int BANK_W  = 8;
    localparam int OFS_W   = 16;
    localparam int ADDR_W  = BANK_W + OFS_W;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 4;
    localparam int PTR_MAX = ADDR_W / BYTE_W;
    localparam int CNT_W   = $clog2(PTR_MAX + 1);

    typedef enum logic [MODE_W-1:0] {
        AM_ABS_DATA    = 4'd0,
        AM_ABS_CTRL    = 4'd1,
        AM_ABS_X       = 4'd2,
        AM_ABS_Y       = 4'd3,
        AM_DP          = 4'd4,
        AM_DP_X        = 4'd5,
        AM_DP_Y        = 4'd6,
        AM_DP_IND_Y    = 4'd7,
        AM_DP_INDL_Y   = 4'd8,
        AM_SR_IND_Y    = 4'd9,
        AM_JMP_IND     = 4'd10,
        AM_JMP_IDX_IND = 4'd11,
        AM_LONG        = 4'd12,
        AM_LONG_X      = 4'd13
    } am_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } st_e;

    typedef struct packed {
        st_e                        st;
        logic [MODE_W-1:0]          mode;
        logic [CNT_W-1:0]           cnt;
        logic [CNT_W-1:0]           last;
        logic [ADDR_W-1:0]          ptr_base;
        logic [PTR_MAX*BYTE_W-1:0]  ptr;
        logic [BANK_W-1:0]          dbank;
        logic [BANK_W-1:0]          pbank;
        logic [OFS_W-1:0]           yi;
        logic [ADDR_W-1:0]          ea;
        logic                       vld;
        logic                       err;
    } regs_t;
endpackage

// File: rtl/ea_idx_mask.sv
module ea_idx_mask #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         narrow_i,
    output logic [W-1:0] val_o
);
    generate
        if (NW < W) begin : g_mask
            assign val_o = narrow_i ? {{(W-NW){1'b0}}, val_i[NW-1:0]} : val_i;
        end else begin : g_pass
            logic narrow_unused;
            assign narrow_unused = narrow_i;
            assign val_o = val_i;
        end
    endgenerate
endmodule

// File: rtl/ea_setup.sv
module ea_setup
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [ADDR_W-1:0]  opnd_i,
    input  logic [BANK_W-1:0]  dbank_i,
    input  logic [BANK_W-1:0]  pbank_i,
    input  logic [OFS_W-1:0]   dpage_i,
    input  logic [OFS_W-1:0]   xi_i,
    input  logic [OFS_W-1:0]   yi_i,
    input  logic [OFS_W-1:0]   sp_i,
    output logic [ADDR_W-1:0]  direct_ea_o,
    output logic [ADDR_W-1:0]  ptr_base_o,
    output logic [CNT_W-1:0]   nbytes_o,
    output logic               bad_o
);
    localparam logic [BANK_W-1:0] BANK0 = '0;

    logic [OFS_W-1:0]  op16;
    logic [OFS_W-1:0]  op8_ext;
    logic [OFS_W-1:0]  dp_sum;
    logic [OFS_W-1:0]  sr_sum;
    logic [OFS_W-1:0]  jx_sum;
    logic [ADDR_W-1:0] x_ext;
    logic [ADDR_W-1:0] y_ext;
    logic [ADDR_W-1:0] abs_data;

    always_comb begin
        op16     = opnd_i[OFS_W-1:0];
        op8_ext  = {{(OFS_W-BYTE_W){1'b0}}, opnd_i[BYTE_W-1:0]};
        dp_sum   = dpage_i + op8_ext;
        sr_sum   = sp_i + op8_ext;
        jx_sum   = op16 + xi_i;
        x_ext    = {BANK0, xi_i};
        y_ext    = {BANK0, yi_i};
        abs_data = {dbank_i, op16};
    end

    always_comb begin
        direct_ea_o = '0;
        ptr_base_o  = '0;
        nbytes_o    = '0;
        bad_o       = 1'b0;
        case (mode_i)
            AM_ABS_DATA:    direct_ea_o = abs_data;
            AM_ABS_CTRL:    direct_ea_o = {pbank_i, op16};
            AM_ABS_X:       direct_ea_o = abs_data + x_ext;
            AM_ABS_Y:       direct_ea_o = abs_data + y_ext;
            AM_DP:          direct_ea_o = {BANK0, dp_sum};
            AM_DP_X:        direct_ea_o = {BANK0, OFS_W'(dp_sum + xi_i)};
            AM_DP_Y:        direct_ea_o = {BANK0, OFS_W'(dp_sum + yi_i)};
            AM_DP_IND_Y: begin
                ptr_base_o = {BANK0, dp_sum};
                nbytes_o   = CNT_W'(2);
            end
            AM_DP_INDL_Y: begin
                ptr_base_o = {BANK0, dp_sum};
                nbytes_o   = CNT_W'(3);
            end
            AM_SR_IND_Y: begin
                ptr_base_o = {BANK0, sr_sum};
                nbytes_o   = CNT_W'(2);
            end
            AM_JMP_IND: begin
                ptr_base_o = {BANK0, op16};
                nbytes_o   = CNT_W'(2);
            end
            AM_JMP_IDX_IND: begin
                ptr_base_o = {pbank_i, jx_sum};
                nbytes_o   = CNT_W'(2);
            end
            AM_LONG:        direct_ea_o = opnd_i;
            AM_LONG_X:      direct_ea_o = opnd_i + x_ext;
            default:        bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_finish.sv
module ea_finish
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0]         mode_i,
    input  logic [PTR_MAX*BYTE_W-1:0] ptr_i,
    input  logic [BANK_W-1:0]         dbank_i,
    input  logic [BANK_W-1:0]         pbank_i,
    input  logic [OFS_W-1:0]          yi_i,
    output logic [ADDR_W-1:0]         ea_o
);
    localparam logic [BANK_W-1:0] BANK0 = '0;

    logic [ADDR_W-1:0] y_ext;
    logic [OFS_W-1:0]  ptr16;

    always_comb begin
        y_ext = {BANK0, yi_i};
        ptr16 = ptr_i[OFS_W-1:0];
        case (mode_i)
            AM_DP_IND_Y,
            AM_SR_IND_Y:    ea_o = {dbank_i, ptr16} + y_ext;
            AM_DP_INDL_Y:   ea_o = ptr_i[ADDR_W-1:0] + y_ext;
            AM_JMP_IND,
            AM_JMP_IDX_IND: ea_o = {pbank_i, ptr16};
            default:        ea_o = '0;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [ADDR_W-1:0]   opnd_i,
    input  logic [BANK_W-1:0]   dbank_i,
    input  logic [BANK_W-1:0]   pbank_i,
    input  logic [OFS_W-1:0]    dpage_i,
    input  logic [OFS_W-1:0]    x_i,
    input  logic [OFS_W-1:0]    y_i,
    input  logic [OFS_W-1:0]    sp_i,
    input  logic                idx8_i,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [BYTE_W-1:0]   mem_rdata_i,
    output logic                busy_o,
    output logic [ADDR_W-1:0]   ea_o,
    output logic                ea_valid_o,
    output logic                ea_err_o
);
    regs_t q, d;

    logic [OFS_W-1:0]          xi_m, yi_m;
    logic [ADDR_W-1:0]         s_direct, s_base;
    logic [CNT_W-1:0]          s_nbytes;
    logic                      s_bad;
    logic [PTR_MAX*BYTE_W-1:0] ptr_nx;
    logic [ADDR_W-1:0]         fin_ea;
    logic                      fetching;

    ea_idx_mask #(.W(OFS_W), .NW(BYTE_W)) u_xmask (
        .val_i(x_i), .narrow_i(idx8_i), .val_o(xi_m)
    );
    ea_idx_mask #(.W(OFS_W), .NW(BYTE_W)) u_ymask (
        .val_i(y_i), .narrow_i(idx8_i), .val_o(yi_m)
    );

    ea_setup u_setup (
        .mode_i      (mode_i),
        .opnd_i      (opnd_i),
        .dbank_i     (dbank_i),
        .pbank_i     (pbank_i),
        .dpage_i     (dpage_i),
        .xi_i        (xi_m),
        .yi_i        (yi_m),
        .sp_i        (sp_i),
        .direct_ea_o (s_direct),
        .ptr_base_o  (s_base),
        .nbytes_o    (s_nbytes),
        .bad_o       (s_bad)
    );

    assign fetching = (q.st == ST_FETCH);

    // Byte lane capture: the lane selected by the byte counter takes the read data.
    for (genvar g = 0; g < PTR_MAX; g++) begin : g_lane
        assign ptr_nx[g*BYTE_W +: BYTE_W] =
            (fetching && q.cnt == CNT_W'(g)) ? mem_rdata_i : q.ptr[g*BYTE_W +: BYTE_W];
    end

    ea_finish u_finish (
        .mode_i  (q.mode),
        .ptr_i   (ptr_nx),
        .dbank_i (q.dbank),
        .pbank_i (q.pbank),
        .yi_i    (q.yi),
        .ea_o    (fin_ea)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (s_bad) begin
                        d.err = 1'b1;
                    end else if (s_nbytes == '0) begin
                        d.ea  = s_direct;
                        d.vld = 1'b1;
                    end else begin
                        d.st       = ST_FETCH;
                        d.mode     = mode_i;
                        d.cnt      = '0;
                        d.last     = s_nbytes - CNT_W'(1);
                        d.ptr_base = s_base;
                        d.ptr      = '0;
                        d.dbank    = dbank_i;
                        d.pbank    = pbank_i;
                        d.yi       = yi_m;
                    end
                end
            end
            ST_FETCH: begin
                d.ptr = ptr_nx;
                if (q.cnt == q.last) begin
                    d.st  = ST_IDLE;
                    d.ea  = fin_ea;
                    d.vld = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_o   = fetching;
    assign mem_addr_o = fetching
        ? {q.ptr_base[ADDR_W-1:OFS_W], OFS_W'(q.ptr_base[OFS_W-1:0] + OFS_W'(q.cnt))}
        : '0;
    assign busy_o     = fetching;
    assign ea_o       = q.ea;
    assign ea_valid_o = q.vld;
    assign ea_err_o   = q.err;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import ea_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              ea_valid_o,
    input logic              ea_err_o
);
    // R11: reads happen only during a fetch
    p_rd_in_fetch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_o |-> busy_o);

    // R12: error and valid strobes never coincide
    p_err_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ea_valid_o && ea_err_o));

    // R11: an accepted request answers in the next cycle with a result, an error or a read
    p_start_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (ea_valid_o || ea_err_o || mem_rd_o));

    // R10: consecutive pointer reads keep the bank byte
    p_ptr_bank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_rd_o && $past(mem_rd_o)) |->
            (mem_addr_o[ADDR_W-1:OFS_W] == $past(mem_addr_o[ADDR_W-1:OFS_W])));

    // R10: consecutive pointer reads step the offset by one, wrapping at 16 bits
    p_ptr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_rd_o && $past(mem_rd_o)) |->
            (mem_addr_o[OFS_W-1:0] == OFS_W'($past(mem_addr_o[OFS_W-1:0]) + 16'd1)));

    // R11: the end of a fetch is marked by the result strobe
    p_fetch_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> ea_valid_o);
endmodule

bind ea_gen ea_gen_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .ea_valid_o (ea_valid_o),
    .ea_err_o   (ea_err_o)
);

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [23:0] opnd = '0;
    logic [7:0]  dbank = '0, pbank = '0;
    logic [15:0] dpage = '0, xr = '0, yr = '0, sp = '0;
    logic        idx8 = 1'b0;
    logic        mem_rd;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic [23:0] ea;
    logic        ea_valid, ea_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mfun(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ (a[23:16] + 8'h3C) ^ 8'hA7;
    endfunction

    assign mem_rdata = mem_rd ? mfun(mem_addr) : 8'h00;

    ea_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .opnd_i(opnd),
        .dbank_i(dbank), .pbank_i(pbank), .dpage_i(dpage), .x_i(xr), .y_i(yr),
        .sp_i(sp), .idx8_i(idx8), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .ea_o(ea), .ea_valid_o(ea_valid),
        .ea_err_o(ea_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [3:0] m);
        case (m)
            4'd0, 4'd1:        return "R2";
            4'd2, 4'd3:        return "R3 R4";
            4'd4, 4'd5, 4'd6:  return "R5 R4";
            4'd7, 4'd8:        return "R6 R10 R4";
            4'd9:              return "R7 R10 R4";
            4'd10, 4'd11:      return "R8 R10 R4";
            4'd12, 4'd13:      return "R9 R4";
            default:           return "R12";
        endcase
    endfunction

    // Arithmetic model written from the requirements.
    task automatic model(input logic [3:0] m, input logic [23:0] op, input logic [7:0] db,
                         input logic [7:0] pb, input logic [15:0] dp, input logic [15:0] x,
                         input logic [15:0] y, input logic [15:0] s, input logic n8,
                         output logic [23:0] e, output int nb, output logic [23:0] base,
                         output logic bad);
        logic [15:0] xi, yi, o16, o8;
        logic [23:0] p;
        xi = n8 ? {8'h00, x[7:0]} : x;
        yi = n8 ? {8'h00, y[7:0]} : y;
        o16 = op[15:0];
        o8 = {8'h00, op[7:0]};
        nb = 0; base = '0; bad = 0; e = '0;
        case (m)
            4'd0:  e = {db, o16};
            4'd1:  e = {pb, o16};
            4'd2:  e = {db, o16} + {8'h00, xi};
            4'd3:  e = {db, o16} + {8'h00, yi};
            4'd4:  e = {8'h00, 16'(dp + o8)};
            4'd5:  e = {8'h00, 16'(dp + o8 + xi)};
            4'd6:  e = {8'h00, 16'(dp + o8 + yi)};
            4'd7, 4'd8: begin base = {8'h00, 16'(dp + o8)}; nb = (m == 4'd7) ? 2 : 3; end
            4'd9:  begin base = {8'h00, 16'(s + o8)}; nb = 2; end
            4'd10: begin base = {8'h00, o16}; nb = 2; end
            4'd11: begin base = {pb, 16'(o16 + xi)}; nb = 2; end
            4'd12: e = op;
            4'd13: e = op + {8'h00, xi};
            default: bad = 1;
        endcase
        if (nb > 0) begin
            p = '0;
            for (int i = 0; i < nb; i++)
                p[i*8 +: 8] = mfun({base[23:16], 16'(base[15:0] + 16'(i))});
            case (m)
                4'd7, 4'd9: e = {db, p[15:0]} + {8'h00, yi};
                4'd8:       e = p + {8'h00, yi};
                default:    e = {pb, p[15:0]};
            endcase
        end
    endtask

    task automatic drive(input logic [3:0] m, input logic [23:0] op, input logic [7:0] db,
                         input logic [7:0] pb, input logic [15:0] dp, input logic [15:0] x,
                         input logic [15:0] y, input logic [15:0] s, input logic n8);
        mode = m; opnd = op; dbank = db; pbank = pb; dpage = dp;
        xr = x; yr = y; sp = s; idx8 = n8;
    endtask

    task automatic run_one(input logic [3:0] m, input logic [23:0] op, input logic [7:0] db,
                           input logic [7:0] pb, input logic [15:0] dp, input logic [15:0] x,
                           input logic [15:0] y, input logic [15:0] s, input logic n8,
                           input bit restart);
        logic [23:0] e, base;
        logic [23:0] rd_a [0:7];
        int nb, k, n;
        logic bad;
        bit rd_ok;
        string tg;
        model(m, op, db, pb, dp, x, y, s, n8, e, nb, base, bad);
        tg = mode_tag(m);
        @(negedge clk);
        drive(m, op, db, pb, dp, x, y, s, n8);
        start = 1'b1;
        @(negedge clk);
        start = restart;
        if (restart) drive(4'd0, ~op, ~db, ~pb, ~dp, ~x, ~y, ~s, ~n8);
        n = 1; k = 0;
        while (1) begin
            if (mem_rd && k < 8) begin rd_a[k] = mem_addr; k++; end
            if (ea_valid || ea_err || n >= 8) break;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        start = 1'b0;
        if (restart) tg = {tg, " R13"};
        if (bad)
            check(ea_err && !ea_valid, tg, {30'd0, ea_err, ea_valid}, 32'd2);
        else
            check(ea_valid && ea == e, tg, {7'd0, ea_valid, ea}, {8'd1, e});
        check(n == ((bad || nb == 0) ? 1 : nb + 1), "R11 latency", n,
              (bad || nb == 0) ? 1 : nb + 1);
        rd_ok = (k == nb);
        for (int i = 0; i < 8; i++)
            if (i < k && i < nb && rd_a[i] != {base[23:16], 16'(base[15:0] + 16'(i))})
                rd_ok = 0;
        check(rd_ok, {tg, " R11 read sequence"}, k, nb);
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check(!ea_valid && !ea_err && !busy && !mem_rd, "R1 reset",
              {28'd0, ea_valid, ea_err, busy, mem_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ea_valid && !ea_err && !busy && !mem_rd, "R1 after release",
              {28'd0, ea_valid, ea_err, busy, mem_rd}, 32'd0);
        for (int m = 0; m < 16; m++) begin
            for (int w = 0; w < 2; w++) begin
                run_one(4'(m), 24'h7F_FFF8, 8'hFF, 8'h7E, 16'hFF80, 16'hAB20,
                        16'hC3F0, 16'hFFE0, w[0], 1'b0);
                run_one(4'(m), 24'h12_34FF, 8'h01, 8'hC0, 16'hFF00, 16'h0001,
                        16'h00FF, 16'hFF00, w[0], 1'b0);
                for (int p = 0; p < 4; p++) begin
                    logic [23:0] o; logic [15:0] d, xv, yv, sv; logic [7:0] b1, b2;
                    lcg = lcg * 32'd1664525 + 32'd1013904223; o = lcg[31:8]; b1 = lcg[7:0];
                    lcg = lcg * 32'd1664525 + 32'd1013904223; d = lcg[31:16]; xv = lcg[15:0];
                    lcg = lcg * 32'd1664525 + 32'd1013904223; yv = lcg[31:16]; sv = lcg[15:0];
                    lcg = lcg * 32'd1664525 + 32'd1013904223; b2 = lcg[23:16];
                    run_one(4'(m), o, b1, b2, d, xv, yv, sv, w[0], 1'b0);
                end
            end
        end
        // R13: new request during a fetch is ignored
        run_one(4'd8, 24'h00_20F0, 8'h44, 8'h55, 16'h1200, 16'h0300, 16'h8001,
                16'h0100, 1'b0, 1'b1);
        run_one(4'd11, 24'h00_FFFE, 8'h44, 8'h9A, 16'h1200, 16'h0005, 16'h8001,
                16'h0100, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule